// File: doc/BRIEF.md
# Language Card Bank-Switch Controller

This block is the control and decode logic of a 16 KB RAM expansion card on an 8-bit microprocessor bus. It watches every bus access. An access to one of sixteen soft-switch addresses in the card's slot I/O page changes three pieces of state: the read source (card RAM or ROM), a write-enable progress counter, and which of two 4 KB RAM banks is mapped at $D000–$DFFF. An access to $D000–$FFFF is turned into a RAM read enable, a RAM write enable or a ROM select, together with a 14-bit RAM address.

The read source and the bank come straight from the soft-switch address bits. Enabling RAM writes is deliberately harder. It takes two qualifying read-cycle accesses to the soft switches, and a write-cycle access to any soft switch cancels the progress. This guards the RAM against a single stray access. The RAM and ROM arrays, bus timing and the CPU sit outside the block.

Top module: `lc_bank_ctrl`

## Requirements
- R1: After reset, reads of $D000–$FFFF select ROM, writes to that range reach RAM, and bank 2 is mapped at $D000–$DFFF.
- R2: The soft switches are the sixteen addresses $C080 + 16*SLOT + n (n = 0..15). A valid access anywhere else changes no state.
- R3: Soft-switch address bit 3 picks the bank: 0 maps bank 2 and 1 maps bank 1. Bank 1 occupies RAM addresses 14'h0000–14'h0FFF and bank 2 occupies 14'h1000–14'h1FFF.
- R4: Soft-switch low bits 2'b00 select RAM for reads and disable writes. Low bits 2'b10 select ROM for reads and disable writes.
- R5: Low bits 2'b01 select ROM for reads and 2'b11 select RAM for reads. Both advance the write state one step: disabled to half-enabled, then to enabled, and it saturates at enabled. RAM writes happen only in the enabled state.
- R6: A write-cycle access to a soft switch applies its bank and read-source decode, then leaves writes disabled.
- R7: A read of $D000–$FFFF while ROM is the read source asserts rom_sel over the whole range and never ram_rd_en. While RAM is the read source it asserts ram_rd_en and never rom_sel.
- R8: $E000–$FFFF maps to RAM address {1'b1, addr[12:0]} (14'h2000–14'h3FFF), independent of the bank.
- R9: A write to $D000–$FFFF asserts ram_wr_en exactly when the write state is enabled, whatever the read source.
- R10: With bus_valid low, or for an address below $D000 (soft switches included), ram_rd_en, ram_wr_en and rom_sel are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_we | input | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | input | 16 | Bus address |
| ram_rd_en | output | 1 | Card RAM drives read data |
| ram_wr_en | output | 1 | Card RAM write strobe |
| rom_sel | output | 1 | ROM drives read data |
| ram_addr | output | 14 | Card RAM address |

## Verification
The hardest state to reach is the half-enabled write state, because no output shows it directly. It shows up only as a write strobe that is missing after one qualifying access and present after a second. The stimulus reaches it from both the disabled state and a freshly cancelled state. It probes with RAM writes after one qualifying access and again after the second. It also issues a write-cycle soft-switch access whose low bits would otherwise advance the counter, to show that the cancel comes after the mode decode.

// File: rtl/lc_bank_ctrl.sv
module lc_bank_ctrl #(
  parameter int SLOT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  output logic        ram_rd_en,
  output logic        ram_wr_en,
  output logic        rom_sel,
  output logic [13:0] ram_addr
);
  localparam logic [11:0] PAGE = 12'hC08 + 12'(SLOT);
  localparam logic [1:0] W_OFF = 2'd0, W_HALF = 2'd1, W_ON = 2'd2;

  logic       rd_ram, bank2;
  logic [1:0] wr_st;
  logic       rd_ram_n;
  logic [1:0] wr_st_n;

  logic sw_hit, hi_hit;
  assign sw_hit = bus_valid && (bus_addr[15:4] == PAGE);
  assign hi_hit = bus_valid && (bus_addr[15:12] >= 4'hD);

  always_comb begin
    rd_ram_n = rd_ram;
    wr_st_n  = wr_st;
    case (bus_addr[1:0])
      2'b00: begin rd_ram_n = 1'b1; wr_st_n = W_OFF; end
      2'b10: begin rd_ram_n = 1'b0; wr_st_n = W_OFF; end
      2'b01: begin rd_ram_n = 1'b0; wr_st_n = (wr_st == W_ON) ? W_ON : wr_st + 2'd1; end
      default: begin rd_ram_n = 1'b1; wr_st_n = (wr_st == W_ON) ? W_ON : wr_st + 2'd1; end
    endcase
    if (bus_we) wr_st_n = W_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ram <= 1'b0;
      wr_st  <= W_ON;
      bank2  <= 1'b1;
    end else if (sw_hit) begin
      rd_ram <= rd_ram_n;
      wr_st  <= wr_st_n;
      bank2  <= ~bus_addr[3];
    end
  end

  assign ram_rd_en = hi_hit && !bus_we && rd_ram;
  assign rom_sel   = hi_hit && !bus_we && !rd_ram;
  assign ram_wr_en = hi_hit && bus_we && (wr_st == W_ON);
  assign ram_addr  = (bus_addr[15:12] == 4'hD) ? {1'b0, bank2, bus_addr[11:0]}
                                               : {1'b1, bus_addr[12:0]};
endmodule

// File: rtl/lc_bank_ctrl_chk.sv
module lc_bank_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic        ram_rd_en,
  input logic        ram_wr_en,
  input logic        rom_sel,
  input logic        sw_hit,
  input logic [1:0]  wr_st,
  input logic        bank2
);
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd_en && rom_sel));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (!ram_rd_en && !ram_wr_en && !rom_sel));

  p_wr_only_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> (bus_we && bus_addr[15:12] >= 4'hD));

  p_sw_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hit && bus_we) |=> (wr_st == 2'd0));

  p_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hit |=> (bank2 == !$past(bus_addr[3])));

  p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st != 2'd3);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_hit |=> ($stable(wr_st) && $stable(bank2)));
endmodule

bind lc_bank_ctrl lc_bank_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
  .rom_sel(rom_sel), .sw_hit(sw_hit), .wr_st(wr_st), .bank2(bank2)
);

// File: tb/test_lc_bank_ctrl.sv
module test_lc_bank_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic ram_rd_en, ram_wr_en, rom_sel;
  logic [13:0] ram_addr;

  int total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic rd; logic wr; logic rom; logic [13:0] a; string tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  lc_bank_ctrl i_lc_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
    .rom_sel(rom_sel), .ram_addr(ram_addr)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      total++;
      if (ram_rd_en !== e.rd || ram_wr_en !== e.wr || rom_sel !== e.rom ||
          ((e.rd || e.wr) && ram_addr !== e.a)) begin
        bad++;
        $display("FAIL %s addr=%h: got rd=%b wr=%b rom=%b a=%h exp rd=%b wr=%b rom=%b a=%h",
                 e.tag, bus_addr, ram_rd_en, ram_wr_en, rom_sel, ram_addr,
                 e.rd, e.wr, e.rom, e.a);
      end
    end
  end

  task automatic acc(input logic v, input logic we, input logic [15:0] a,
                     input logic rd, input logic wr, input logic rom,
                     input logic [13:0] ea, input string tag);
    item_t e;
    @(posedge clk); #1;
    bus_valid = v; bus_we = we; bus_addr = a;
    e.rd = rd; e.wr = wr; e.rom = rom; e.a = ea; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic sw(input logic we, input logic [3:0] n);
    acc(1'b1, we, 16'hC080 | 16'(n), 1'b0, 1'b0, 1'b0, 14'h0, "R10 switch");
  endtask

  task automatic rd(input logic [15:0] a, input logic r, input logic rom,
                    input logic [13:0] ea, input string tag);
    acc(1'b1, 1'b0, a, r, 1'b0, rom, ea, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic w,
                    input logic [13:0] ea, input string tag);
    acc(1'b1, 1'b1, a, 1'b0, w, 1'b0, ea, tag);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    bus_valid = 1'b0; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(16'hD123, 1'b0, 1'b1, 14'h0, "R1 reset rom read");
    wr(16'hD123, 1'b1, 14'h1123, "R1 reset write bank2");
    wr(16'hE456, 1'b1, 14'h2456, "R8 upper map");
    rd(16'hFFFF, 1'b0, 1'b1, 14'h0, "R7 rom top");

    sw(1'b0, 4'h8);
    rd(16'hD010, 1'b1, 1'b0, 14'h0010, "R3 bank1 R4 ram read");
    wr(16'hD010, 1'b0, 14'h0, "R4 write off");
    rd(16'hF000, 1'b1, 1'b0, 14'h3000, "R8 ram upper");

    sw(1'b0, 4'h1);
    wr(16'hD000, 1'b0, 14'h0, "R5 half not enough");
    rd(16'hD000, 1'b0, 1'b1, 14'h0, "R5 01 rom read");
    sw(1'b0, 4'h1);
    wr(16'hD000, 1'b1, 14'h1000, "R9 write with rom source");
    sw(1'b0, 4'hB);
    wr(16'hDFFF, 1'b1, 14'h0FFF, "R5 saturate bank1");
    rd(16'hDFFF, 1'b1, 1'b0, 14'h0FFF, "R7 ram source");

    sw(1'b1, 4'h3);
    rd(16'hD000, 1'b1, 1'b0, 14'h1000, "R6 mode applied");
    wr(16'hD000, 1'b0, 14'h0, "R6 write cancelled");

    sw(1'b0, 4'h2);
    rd(16'hE000, 1'b0, 1'b1, 14'h0, "R4 10 rom read");
    wr(16'hE000, 1'b0, 14'h0, "R4 10 write off");
    sw(1'b0, 4'h3);
    wr(16'hE000, 1'b0, 14'h0, "R5 half after off");
    sw(1'b0, 4'h3);
    wr(16'hE000, 1'b1, 14'h2000, "R5 enabled");

    acc(1'b1, 1'b0, 16'hC098, 1'b0, 1'b0, 1'b0, 14'h0, "R2 other page");
    acc(1'b1, 1'b1, 16'hC07A, 1'b0, 1'b0, 1'b0, 14'h0, "R2 below page");
    rd(16'hD000, 1'b1, 1'b0, 14'h1000, "R2 bank kept");
    wr(16'hD001, 1'b1, 14'h1001, "R2 write kept");
    acc(1'b0, 1'b1, 16'hD000, 1'b0, 1'b0, 1'b0, 14'h0, "R10 not valid");
    rd(16'hC800, 1'b0, 1'b0, 14'h0, "R10 below range");
    wr(16'h8000, 1'b0, 14'h0, "R10 low write");

    do_reset();
    rd(16'hD000, 1'b0, 1'b1, 14'h0, "R1 reset again rom");
    wr(16'hD000, 1'b1, 14'h1000, "R1 reset again bank2");

    @(posedge clk); #1 bus_valid = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule